// File: doc/BRIEF.md
# Display Identification Block Reader

This block is an I2C master with a single job: it fetches one 128-byte block of display identification data from a monitor over the display data channel and stores it in a local buffer. Software writes the SCL divider, the buffer start offset and the word address (0x00 or 0x80) through a small byte-wide register port. It then writes the segment pointer, and that write starts the fetch. When the fetch ends, a ready flag or an error flag is set in a status register. Either flag can raise the interrupt line if its mask bit is set. Software then drains the bytes one at a time through a single data address. Each read of that address moves an internal read pointer forward.

The bus is open drain. The block only ever pulls SCL or SDA low, through its two enable outputs, and it reads the real bus levels back on its two inputs. When the segment pointer is zero, the sequence is: START, 0xA0, word address, repeated START, 0xA1, then 128 data bytes, the last one NACKed, then STOP. When the segment pointer is nonzero, the sequence begins with START, 0x60 and the segment value, and then continues with the zero-segment sequence.

The control state machine has seven states:
- ST_IDLE goes to ST_START on a segment write.
- ST_START goes to ST_TX.
- ST_TX goes to ST_TACK after eight bits.
- ST_TACK goes to ST_STOP on a NACK of an address byte. It goes to ST_START (repeated start) after the segment value or the word address. It goes to ST_TX for the next written byte, and to ST_RX after the read address.
- ST_RX goes to ST_MACK after eight bits.
- ST_MACK goes back to ST_RX, or to ST_STOP after the last byte.
- ST_STOP goes to ST_IDLE and reports the result.

Top module: `edid_fetch`

## Requirements
- R1: After reset the status register (address 6) reads 0, irq is low, and both pad enables are low (bus released).
- R2: The divider is a 16-bit value: address 0 holds the low byte and address 1 holds the high byte. Each bit slot lasts four quarter periods of DIV+1 clocks each. Without stretching, consecutive SCL rising edges are 4*(DIV+1) clocks apart.
- R3: A write to address 4 in idle starts a fetch with the written value as segment pointer. The sequence is the one given above. A zero segment skips the 0x60 phase.
- R4: Received bytes go into the buffer starting at the offset in address 2. Reads of address 7 return the byte at the read pointer and advance it. A fetch start resets the read pointer to the offset.
- R5: Reads of address 7 at buffer entry 127 keep returning entry 127 and do not wrap.
- R6: Status bit 0 is set when a fetch completes. A NACK on any address byte (0x60, 0xA0, 0xA1) ends the fetch with STOP and sets status bit 1 instead of bit 0.
- R7: Writing 1 to a status bit clears it. Writing 0 to a status bit leaves it unchanged.
- R8: irq is high exactly when some status bit has its mask bit set (address 5, bit 0 ready, bit 1 error). A mask of 0 keeps irq low while status stays readable.
- R9: After releasing SCL, the engine waits while the bus holds SCL low (clock stretching). The data is still fetched intact.
- R10: SCL and SDA are only pulled low (enable = 1) or released. The buffer contents equal the bytes the device sent, starting at its word address and segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (advances the buffer at address 7) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on reg_addr) |
| scl_in | input | 1 | SCL level on the bus |
| sda_in | input | 1 | SDA level on the bus |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| irq | output | 1 | Masked status interrupt |

## Verification
The bench attacks five kinds of fault:
- Segment handling, with zero and nonzero segments. An engine that always sent, or never sent, the 0x60 phase would fetch the wrong block.
- Word address 0x80. An engine that ignored it would return data offset by 128.
- A refused address byte, both the 0x60 and the 0xA0 phase. A design that ignored the NACK would raise ready instead of error and would hang on the bus.
- A device that stretches every low phase. An engine that did not wait would sample bits too early and corrupt the bytes.
- Reading past the end of the buffer and clear-on-write-one. A wrapping pointer would return byte 0. A plain-write status would lose a flag on a write of 0. The SCL edge spacing is measured at a divider with a nonzero high byte, which catches a dropped high byte.

// File: rtl/edid_pkg.sv
package edid_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_TX, ST_TACK, ST_RX, ST_MACK, ST_STOP
    } ddc_state_t;

    localparam logic [2:0] A_DIV_LO = 3'd0;
    localparam logic [2:0] A_DIV_HI = 3'd1;
    localparam logic [2:0] A_FOFS   = 3'd2;
    localparam logic [2:0] A_WORD   = 3'd3;
    localparam logic [2:0] A_SEG    = 3'd4;
    localparam logic [2:0] A_MASK   = 3'd5;
    localparam logic [2:0] A_STAT   = 3'd6;
    localparam logic [2:0] A_DATA   = 3'd7;

    localparam logic [6:0] DEV_SEG  = 7'h30;
    localparam logic [6:0] DEV_EDID = 7'h50;
endpackage

// File: rtl/edid_tick.sv
module edid_tick #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [DW-1:0] div,
    output logic          tick
);
    logic [DW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt <= '0;
        else if (!run || cnt == div) cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt == div);

    // R2: with a divider above zero, quarter ticks never come back to back
    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div != '0 && $stable(div)) |=> !tick);
endmodule

// File: rtl/edid_fifo.sv
module edid_fifo #(
    parameter int DEPTH = 128,
    parameter int W     = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [$clog2(DEPTH)-1:0] ofs,
    input  logic                     wr_en,
    input  logic [W-1:0]             wdata,
    input  logic                     rd_adv,
    output logic [W-1:0]             rdata
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
        end else if (load) begin
            wptr <= ofs;
            rptr <= ofs;
        end else begin
            if (wr_en)                  wptr <= wptr + 1'b1;
            if (rd_adv && rptr != LAST) rptr <= rptr + 1'b1;
        end
    end

    assign rdata = mem[rptr];

    // R5: the read pointer holds at the last entry
    a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_adv && !load && rptr == LAST) |=> rptr == LAST);
endmodule

// File: rtl/edid_ctrl.sv
module edid_ctrl
    import edid_pkg::*;
#(
    parameter int NBYTES = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] seg,
    input  logic [7:0] word,
    input  logic       tick,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       busy,
    output logic       scl_low,
    output logic       sda_low,
    output logic       fifo_we,
    output logic [7:0] fifo_wd,
    output logic       done_ok,
    output logic       done_err
);
    localparam int CW = $clog2(NBYTES);
    localparam logic [CW-1:0] CLAST = CW'(NBYTES - 1);

    ddc_state_t    state;
    logic [1:0]    phase;
    logic [2:0]    bitn, step;
    logic [CW-1:0] cnt;
    logic [7:0]    seg_r, word_r, sh, tx_byte;
    logic          nack, err, adv, last;

    assign adv     = tick && !(phase == 2'd1 && !scl_in);
    assign last    = (cnt == CLAST);
    assign busy    = (state != ST_IDLE);
    assign fifo_wd = sh;

    always_comb begin
        case (step)
            3'd0:    tx_byte = {DEV_SEG, 1'b0};
            3'd1:    tx_byte = seg_r;
            3'd2:    tx_byte = {DEV_EDID, 1'b0};
            3'd3:    tx_byte = word_r;
            default: tx_byte = {DEV_EDID, 1'b1};
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE; phase <= '0; bitn <= '0; step <= '0; cnt <= '0;
            seg_r <= '0; word_r <= '0; sh <= '0; nack <= 1'b0; err <= 1'b0;
            fifo_we <= 1'b0; done_ok <= 1'b0; done_err <= 1'b0;
        end else begin
            fifo_we <= 1'b0; done_ok <= 1'b0; done_err <= 1'b0;
            unique case (state)
                ST_IDLE: if (go) begin
                    state  <= ST_START;
                    phase  <= '0;
                    step   <= (seg != 8'd0) ? 3'd0 : 3'd2;
                    seg_r  <= seg;
                    word_r <= word;
                    err    <= 1'b0;
                    cnt    <= '0;
                end
                default: if (adv) begin
                    phase <= phase + 2'd1;
                    if (phase == 2'd2 && state == ST_TACK) nack <= sda_in;
                    if (phase == 2'd2 && state == ST_RX)   sh <= {sh[6:0], sda_in};
                    if (phase == 2'd3) begin
                        unique case (state)
                            ST_START: begin state <= ST_TX; bitn <= 3'd7; end
                            ST_TX: if (bitn == 3'd0) state <= ST_TACK;
                                   else bitn <= bitn - 3'd1;
                            ST_TACK: if (nack && !step[0]) begin
                                    state <= ST_STOP; err <= 1'b1;
                                end else if (step == 3'd4) begin
                                    state <= ST_RX; bitn <= 3'd7;
                                end else if (step[0]) begin
                                    state <= ST_START; step <= step + 3'd1;
                                end else begin
                                    state <= ST_TX; bitn <= 3'd7; step <= step + 3'd1;
                                end
                            ST_RX: if (bitn == 3'd0) begin
                                    state <= ST_MACK; fifo_we <= 1'b1;
                                end else bitn <= bitn - 3'd1;
                            ST_MACK: if (last) state <= ST_STOP;
                                else begin
                                    state <= ST_RX; bitn <= 3'd7; cnt <= cnt + 1'b1;
                                end
                            ST_STOP: begin
                                state <= ST_IDLE; done_ok <= !err; done_err <= err;
                            end
                            default: state <= ST_IDLE;
                        endcase
                    end
                end
            endcase
        end
    end

    // pad outputs
    always_comb begin
        scl_low = 1'b0;
        sda_low = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_START: begin
                scl_low = (phase == 2'd0) || (phase == 2'd3);
                sda_low = (phase >= 2'd2);
            end
            ST_TX: begin
                scl_low = (phase == 2'd0) || (phase == 2'd3);
                sda_low = !tx_byte[bitn];
            end
            ST_TACK, ST_RX: scl_low = (phase == 2'd0) || (phase == 2'd3);
            ST_MACK: begin
                scl_low = (phase == 2'd0) || (phase == 2'd3);
                sda_low = !last;
            end
            ST_STOP: begin
                scl_low = (phase == 2'd0);
                sda_low = (phase <= 2'd1);
            end
            default: ;
        endcase
    end

    // R9: a held-low SCL freezes the slot in its release phase
    a_r9_stretch_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && phase == 2'd1 && !scl_in) |=> phase == 2'd1);
    // R6: ready and error never report together
    a_r6_one_result: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_ok && done_err));
    // R6: the error flag only rises after a sampled NACK
    a_r6_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> $past(nack));
    // R3: SDA holds steady through a transmitted bit after its set-up phase
    a_r3_tx_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TX && phase != 2'd0) |-> $stable(sda_low));
endmodule

// File: rtl/edid_fetch.sv
module edid_fetch
    import edid_pkg::*;
#(
    parameter int NBYTES = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [2:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       scl_oe,
    output logic       sda_oe,
    output logic       irq
);
    localparam int AW = $clog2(NBYTES);

    logic [15:0]   div;
    logic [AW-1:0] fofs;
    logic [7:0]    word, fifo_rd, fifo_wd;
    logic [1:0]    mask, status;
    logic          go, busy, tick, fifo_we, done_ok, done_err, rd_adv;

    assign go     = reg_wr && reg_addr == A_SEG && !busy;
    assign rd_adv = reg_rd && reg_addr == A_DATA;
    assign irq    = |(status & mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div <= '0; fofs <= '0; word <= '0; mask <= '0; status <= '0;
        end else begin
            if (reg_wr) begin
                case (reg_addr)
                    A_DIV_LO: div[7:0]  <= reg_wdata;
                    A_DIV_HI: div[15:8] <= reg_wdata;
                    A_FOFS:   fofs      <= reg_wdata[AW-1:0];
                    A_WORD:   word      <= reg_wdata;
                    A_MASK:   mask      <= reg_wdata[1:0];
                    A_STAT:   status    <= status & ~reg_wdata[1:0];
                    default: ;
                endcase
            end
            if (done_ok)  status[0] <= 1'b1;
            if (done_err) status[1] <= 1'b1;
        end
    end

    always_comb begin
        case (reg_addr)
            A_DIV_LO: reg_rdata = div[7:0];
            A_DIV_HI: reg_rdata = div[15:8];
            A_FOFS:   reg_rdata = 8'(fofs);
            A_WORD:   reg_rdata = word;
            A_MASK:   reg_rdata = {6'd0, mask};
            A_STAT:   reg_rdata = {6'd0, status};
            A_DATA:   reg_rdata = fifo_rd;
            default:  reg_rdata = 8'd0;
        endcase
    end

    edid_tick #(.DW(16)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(busy), .div(div), .tick(tick)
    );

    edid_ctrl #(.NBYTES(NBYTES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .go(go), .seg(reg_wdata), .word(word),
        .tick(tick), .scl_in(scl_in), .sda_in(sda_in), .busy(busy),
        .scl_low(scl_oe), .sda_low(sda_oe), .fifo_we(fifo_we),
        .fifo_wd(fifo_wd), .done_ok(done_ok), .done_err(done_err)
    );

    edid_fifo #(.DEPTH(NBYTES), .W(8)) u_fifo (
        .clk(clk), .rst_n(rst_n), .load(go), .ofs(fofs), .wr_en(fifo_we),
        .wdata(fifo_wd), .rd_adv(rd_adv), .rdata(fifo_rd)
    );

    // R7: a write of one clears the ready flag unless completion lands together
    a_r7_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_STAT && reg_wdata[0] && !done_ok) |=> !status[0]);
    // R8: a zero mask keeps the line quiet
    a_r8_muted: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == 2'b00) |-> !irq);
    // R10: the bus is never driven while idle
    a_r10_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_oe && !sda_oe));
endmodule

// File: tb/edid_fetch_bench.sv
module edid_fetch_bench;
    localparam logic [2:0] R_DLO = 3'd0, R_DHI = 3'd1, R_OFS = 3'd2, R_WORD = 3'd3,
                           R_SEG = 3'd4, R_MASK = 3'd5, R_STAT = 3'd6, R_DATA = 3'd7;

    typedef struct packed {
        logic [7:0]  seg;
        logic [7:0]  word;
        logic [15:0] div;
        logic        stretch;
        logic [7:0]  refuse;
        logic        experr;
    } vec_t;

    localparam vec_t TBL [6] = '{
        '{seg: 8'd0, word: 8'h00, div: 16'd1,     stretch: 1'b0, refuse: 8'h00, experr: 1'b0},
        '{seg: 8'd0, word: 8'h80, div: 16'd3,     stretch: 1'b0, refuse: 8'h00, experr: 1'b0},
        '{seg: 8'd1, word: 8'h00, div: 16'd1,     stretch: 1'b0, refuse: 8'h00, experr: 1'b0},
        '{seg: 8'd0, word: 8'h00, div: 16'd2,     stretch: 1'b1, refuse: 8'h00, experr: 1'b0},
        '{seg: 8'd0, word: 8'h00, div: 16'h0102,  stretch: 1'b0, refuse: 8'hA0, experr: 1'b1},
        '{seg: 8'd2, word: 8'h80, div: 16'd1,     stretch: 1'b0, refuse: 8'h60, experr: 1'b1}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic scl_oe, sda_oe, irq, scl_bus, sda_bus;

    int checks = 0, fails = 0;

    always #4 clk = ~clk;

    // bus device model
    logic       s_low = 1'b0, scl_q = 1'b1, sda_q = 1'b1, m_nack = 1'b0;
    logic       stretch_en = 1'b0;
    logic [7:0] refuse_addr = 8'h00;
    int         hold = 0, s_bits = 0, s_mode = 0;
    logic [7:0] s_sh = '0, s_tgt = '0, s_seg = '0, s_ptr = '0;

    assign scl_bus = !scl_oe && (hold == 0);
    assign sda_bus = !sda_oe && !s_low;

    function automatic logic [7:0] edid_byte(input logic [7:0] sg, input logic [7:0] ix);
        return 8'(ix * 8'd7 + sg * 8'd29 + 8'd3);
    endfunction

    always @(posedge clk) begin
        scl_q <= scl_bus;
        sda_q <= sda_bus;
        if (hold != 0) hold <= hold - 1;
        if (scl_bus && scl_q && sda_q && !sda_bus) begin
            s_mode <= 1; s_bits <= 0; s_low <= 1'b0;
        end else if (scl_bus && scl_q && !sda_q && sda_bus) begin
            s_mode <= 0; s_low <= 1'b0; s_seg <= '0;
        end else if (scl_bus && !scl_q) begin
            if ((s_mode == 1 || s_mode == 2) && s_bits < 8) begin
                s_sh <= {s_sh[6:0], sda_bus}; s_bits <= s_bits + 1;
            end
            if (s_mode == 3 && s_bits == 9) m_nack <= sda_bus;
        end else if (!scl_bus && scl_q) begin
            if (stretch_en) hold <= 12;
            if (s_mode == 1) begin
                if (s_bits == 8) begin
                    if (s_sh != refuse_addr && (s_sh == 8'h60 || s_sh == 8'hA0 || s_sh == 8'hA1)) begin
                        s_low <= 1'b1; s_tgt <= s_sh; s_bits <= 9;
                    end else s_mode <= 0;
                end else if (s_bits == 9) begin
                    if (s_tgt == 8'hA1) begin
                        s_mode <= 3; s_low <= !edid_byte(s_seg, s_ptr)[7]; s_bits <= 1;
                    end else begin
                        s_mode <= 2; s_low <= 1'b0; s_bits <= 0;
                    end
                end
            end else if (s_mode == 2) begin
                if (s_bits == 8) begin
                    if (s_tgt == 8'h60) s_seg <= s_sh; else s_ptr <= s_sh;
                    s_low <= 1'b1; s_bits <= 9;
                end else if (s_bits == 9) begin
                    s_low <= 1'b0; s_bits <= 0;
                end
            end else if (s_mode == 3) begin
                if (s_bits < 8) begin
                    s_low <= !edid_byte(s_seg, s_ptr)[7 - s_bits]; s_bits <= s_bits + 1;
                end else if (s_bits == 8) begin
                    s_low <= 1'b0; s_bits <= 9; s_ptr <= s_ptr + 8'd1;
                end else if (m_nack) begin
                    s_low <= 1'b0; s_mode <= 0;
                end else begin
                    s_low <= !edid_byte(s_seg, s_ptr)[7]; s_bits <= 1;
                end
            end
        end
    end

    // SCL rising-edge spacing
    int cyc = 0, prev_rise = 0, last_gap = 0;
    logic scl_seen = 1'b1;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        scl_seen <= scl_bus;
        if (scl_bus && !scl_seen) begin
            last_gap <= cyc - prev_rise;
            prev_rise <= cyc;
        end
    end

    edid_fetch u_edid_fetch (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .scl_in(scl_bus), .sda_in(sda_bus), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .irq(irq)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic run_fetch(input logic [7:0] sg, input logic [7:0] wd, input logic [15:0] dv,
                             input logic [6:0] ofs);
        wr(R_DLO, dv[7:0]); wr(R_DHI, dv[15:8]); wr(R_OFS, 8'(ofs)); wr(R_WORD, wd);
        wr(R_SEG, sg);
    endtask

    task automatic wait_stat(output logic [7:0] st);
        st = 8'd0;
        for (int n = 0; n < 4000 && st == 8'd0; n++) begin
            repeat (20) @(negedge clk);
            rd(R_STAT, st);
        end
    endtask

    initial begin
        #(8 * 195000);
        checks++; fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] d, st;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        rd(R_STAT, d);
        check(d == 8'd0, "R1 status", d, 0);
        check(!irq, "R1 irq", irq, 0);
        check(!scl_oe && !sda_oe, "R1 pads", {scl_oe, sda_oe}, 0);

        wr(R_MASK, 8'd3);
        foreach (TBL[i]) begin
            stretch_en  = TBL[i].stretch;
            refuse_addr = TBL[i].refuse;
            run_fetch(TBL[i].seg, TBL[i].word, TBL[i].div, 7'd0);
            wait_stat(st);
            // R6: result flag; R8: interrupt follows masked status
            check(st == (TBL[i].experr ? 8'd2 : 8'd1), "R6 result", st, TBL[i].experr ? 2 : 1);
            check(irq, "R8 irq raised", irq, 1);
            if (!TBL[i].stretch) // R2: SCL edge spacing from the 16-bit divider
                check(last_gap == 4 * (int'(TBL[i].div) + 1), "R2 scl period",
                      last_gap, 4 * (int'(TBL[i].div) + 1));
            wr(R_STAT, 8'd3);
            check(!irq, "R7 cleared", irq, 0);
            if (!TBL[i].experr) begin
                // R3 R4 R9 R10: buffer equals the addressed block
                for (int k = 0; k < 128; k++) begin
                    rd(R_DATA, d);
                    check(d == edid_byte(TBL[i].seg, 8'(TBL[i].word + 8'(k))), "R3 data",
                          d, edid_byte(TBL[i].seg, 8'(TBL[i].word + 8'(k))));
                end
            end
        end
        stretch_en = 1'b0; refuse_addr = 8'h00;

        // R8: muted interrupt, status still visible, then unmute
        wr(R_MASK, 8'd0);
        run_fetch(8'd0, 8'h00, 16'd1, 7'd0);
        wait_stat(st);
        check(st == 8'd1, "R8 status while muted", st, 1);
        check(!irq, "R8 muted", irq, 0);
        wr(R_MASK, 8'd1);
        @(negedge clk);
        check(irq, "R8 unmuted", irq, 1);
        // R7: writing 0 keeps the flag, writing 1 clears it
        wr(R_STAT, 8'd2);
        rd(R_STAT, d);
        check(d == 8'd1, "R7 zero write", d, 1);
        wr(R_STAT, 8'd1);
        rd(R_STAT, d);
        check(d == 8'd0, "R7 one write", d, 0);
        // R5: past the end the last byte repeats
        for (int k = 0; k < 128; k++) rd(R_DATA, d);
        rd(R_DATA, d);
        check(d == edid_byte(8'd0, 8'd127), "R5 past end", d, edid_byte(8'd0, 8'd127));
        rd(R_DATA, d);
        check(d == edid_byte(8'd0, 8'd127), "R5 no wrap", d, edid_byte(8'd0, 8'd127));

        // R4: nonzero buffer offset, read pointer starts at it
        run_fetch(8'd0, 8'h00, 16'd1, 7'd5);
        wait_stat(st);
        wr(R_STAT, 8'd3);
        for (int k = 0; k < 3; k++) begin
            rd(R_DATA, d);
            check(d == edid_byte(8'd0, 8'(k)), "R4 offset", d, edid_byte(8'd0, 8'(k)));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule